// File: doc/BRIEF.md
# Vector Unpack Address and Expansion Engine

This block carries out a single unpack command. Packed operand data arrives as a stream of 32-bit words under a valid/ready handshake. The block cuts it into fields and widens each field to a 32-bit lane. It then writes whole 128-bit vectors to a vector data memory through a plain write port made of an enable, a quadword index and the data.

Each command selects three things: an element count of one to four, and an element width of 32, 16 or 8 bits or a packed 16-bit colour code. It also selects sign or zero extension. A cycle length and a write length set how the output vectors spread across the memory. When the write length is the larger of the two, some output vectors are pure fill and draw no input. An optional double-buffer offset can be added to every destination index. All indexes wrap inside the memory.

A one-cycle completion pulse follows the last write. The command fields arrive already decoded and are latched when `start` is seen while the block is idle.

Top module: `unpack_engine`

## Requirements
- R1: Fields are taken from the input stream least significant bit first. A field may straddle two words. Element `e` of a vector occupies `wr_data[32*e+31:32*e]`. The element width is 32, 16 or 8 bits for width code 0, 1 or 2, and a vector uses `count_m1+1` elements.
- R2: Width code 3 selects the colour format: one 16-bit field per vector split, from bit 0 upward, into 5, 5, 5 and 1 bits, giving four elements. When `cmd_unsigned` is 0, every field except the 1-bit one is sign-extended from its top bit (5-bit 0x15 gives 0xFFFFFFF5, 0x0A gives 0x0000000A). When `cmd_unsigned` is 1, fields are zero-extended. The 1-bit field is always zero-extended.
- R3: When the element count is below four (width codes 0 to 2), the unused upper 32-bit lanes of every vector are written as zero.
- R4: A command accepts exactly ceil(bits_per_vector × n / 32) input words. Here n is the number of non-fill vectors. Bits of the last word that are left over are discarded. A word is taken only in a cycle where `in_valid` and `in_ready` are both high.
- R5: When `cyc_cl >= cyc_wl`, output vector k goes to index `cmd_imm + (k / W) * cyc_cl + k % W`. W is `cyc_wl`, or 256 when `cyc_wl` is 0.
- R6: When `cyc_cl < cyc_wl`, output vector k goes to index `cmd_imm + k`. When `k % cyc_wl >= cyc_cl`, that vector is an all-zero fill vector that consumes no input.
- R7: When `cmd_rbit` is 1, `tops` is added to every destination index.
- R8: The destination index wraps modulo MEM_QW quadwords. With 256 quadwords, index 0x3FF lands on 0xFF and the next vector lands on 0x00.
- R9: A command writes `cmd_num` vectors, with 0 meaning 256. When `cmd_num`, `cyc_cl` and `cyc_wl` are all 0, every one of the 256 vectors is a fill vector.
- R10: After reset, `wr_en`, `done` and `in_ready` are low. `done` is high for exactly the one cycle after the last write of a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a command (taken only while idle) |
| cmd_vn | input | 2 | Element count minus one |
| cmd_vl | input | 2 | Width code: 0=32, 1=16, 2=8 bits, 3=colour |
| cmd_unsigned | input | 1 | 1 selects zero extension |
| cmd_rbit | input | 1 | Add `tops` to destination indexes |
| cmd_imm | input | 10 | Base quadword index |
| cmd_num | input | 8 | Output vector count (0 = 256) |
| cyc_cl | input | 8 | Cycle length |
| cyc_wl | input | 8 | Write length (0 = 256) |
| tops | input | 10 | Double-buffer offset |
| in_data | input | 32 | Packed input word |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Engine takes the word this cycle |
| wr_en | output | 1 | Vector write strobe |
| wr_addr | output | $clog2(MEM_QW) | Destination quadword index |
| wr_data | output | 128 | Expanded vector |
| done | output | 1 | Command finished pulse |

## Verification
The main function is tried with all four width codes, in both signed and unsigned mode, and with element counts of one to four. Odd-sized vectors (24 and 48 bits) make fields cross word boundaries and leave partial last words, so they separate correct bit packing and word counting from per-word slicing. Cycle settings cover equal lengths, cl > wl (interleaved gaps), cl < wl (fill vectors), wl = 0 as 256 and the all-zero shortcut, and each gives a different address and consumption pattern. Stalled input, the R bit and indexes near the top of memory show that handshaking, offset addition and wrapping act independently. Fixed words check the exact 5-5-5-1 sign rule.

// File: rtl/unpack_pkg.sv
package unpack_pkg;

    localparam int VEC_W  = 128;
    localparam int WORD_W = 32;
    localparam int STASH_W = VEC_W + WORD_W;
    localparam int LVL_W  = $clog2(STASH_W + 1);

    typedef struct packed {
        logic [1:0] vn;
        logic [1:0] vl;
        logic       uns;
        logic       rbit;
        logic [9:0] imm;
        logic [7:0] num;
        logic [7:0] cl;
        logic [7:0] wl;
        logic [9:0] tops;
    } ucmd_t;

    // bits drawn from the stream for one non-fill vector
    function automatic logic [LVL_W-1:0] vec_bits(logic [1:0] vn, logic [1:0] vl);
        logic [LVL_W-1:0] cnt;
        cnt = LVL_W'(vn) + LVL_W'(1);
        case (vl)
            2'd0:    return cnt << 5;
            2'd1:    return cnt << 4;
            2'd2:    return cnt << 3;
            default: return LVL_W'(16);
        endcase
    endfunction

    function automatic logic [VEC_W-1:0] expand_vec(logic [VEC_W-1:0] raw, logic [1:0] vn,
                                                    logic [1:0] vl, logic uns);
        logic [VEC_W-1:0] v;
        logic [31:0] el;
        logic [15:0] h;
        logic [7:0]  b;
        logic [4:0]  c;
        v = '0;
        if (vl == 2'd3) begin
            for (int i = 0; i < 3; i++) begin
                c = raw[i*5 +: 5];
                v[i*32 +: 32] = uns ? {27'd0, c} : {{27{c[4]}}, c};
            end
            v[96 +: 32] = {31'd0, raw[15]};
        end else begin
            for (int i = 0; i < 4; i++) begin
                case (vl)
                    2'd0: el = raw[i*32 +: 32];
                    2'd1: begin
                        h  = raw[i*16 +: 16];
                        el = uns ? {16'd0, h} : {{16{h[15]}}, h};
                    end
                    default: begin
                        b  = raw[i*8 +: 8];
                        el = uns ? {24'd0, b} : {{24{b[7]}}, b};
                    end
                endcase
                if (i > int'(vn)) el = '0;
                v[i*32 +: 32] = el;
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/unpack_bitbuf.sv
module unpack_bitbuf
    import unpack_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               push,
    input  logic [WORD_W-1:0]  push_word,
    input  logic               pop,
    input  logic [LVL_W-1:0]   pop_bits,
    output logic [VEC_W-1:0]   head,
    output logic [LVL_W-1:0]   level
);
    logic [STASH_W-1:0] stash_q, stash_n;
    logic [LVL_W-1:0]   lvl_q, lvl_n;

    always_comb begin
        stash_n = stash_q;
        lvl_n   = lvl_q;
        if (pop) begin
            stash_n = stash_n >> pop_bits;
            lvl_n   = lvl_n - pop_bits;
        end
        if (push) begin
            stash_n = stash_n | ({{(STASH_W-WORD_W){1'b0}}, push_word} << lvl_n);
            lvl_n   = lvl_n + LVL_W'(WORD_W);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            stash_q <= '0;
            lvl_q   <= '0;
        end else begin
            stash_q <= stash_n;
            lvl_q   <= lvl_n;
        end
    end

    assign head  = stash_q[VEC_W-1:0];
    assign level = lvl_q;

    // R4: gathering stops before the stash can overflow
    a_r4_level_cap: assert property (@(posedge clk) disable iff (rst)
        lvl_q <= LVL_W'(STASH_W));

endmodule

// File: rtl/unpack_addr_gen.sv
module unpack_addr_gen
    import unpack_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          adv,
    input  ucmd_t         cmd,
    output logic [AW-1:0] addr,
    output logic          fill,
    output logic          last
);
    logic [7:0]    k_q;
    logic [7:0]    col_q;
    logic [AW-1:0] base_q;
    logic [8:0]    wl_eff;
    logic          interleave;
    logic          shortcut;
    logic [AW-1:0] off;

    always_comb begin
        wl_eff     = (cmd.wl == 8'd0) ? 9'd256 : {1'b0, cmd.wl};
        interleave = (cmd.cl >= cmd.wl);
        shortcut   = (cmd.num == 8'd0) && (cmd.cl == 8'd0) && (cmd.wl == 8'd0);
        fill       = shortcut || (!interleave && (col_q >= cmd.cl));
        last       = (k_q == cmd.num - 8'd1);
        off        = interleave ? (base_q + AW'(col_q)) : AW'(k_q);
        addr       = AW'(cmd.imm) + off + (cmd.rbit ? AW'(cmd.tops) : AW'(0));
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            k_q    <= '0;
            col_q  <= '0;
            base_q <= '0;
        end else if (adv) begin
            k_q <= k_q + 8'd1;
            if ({1'b0, col_q} + 9'd1 == wl_eff) begin
                col_q  <= '0;
                base_q <= base_q + AW'(cmd.cl);
            end else begin
                col_q <= col_q + 8'd1;
            end
        end
    end

    // R5: the position inside a write block never reaches the write length
    a_r5_col_in_block: assert property (@(posedge clk) disable iff (rst)
        {1'b0, col_q} < wl_eff);

endmodule

// File: rtl/unpack_engine.sv
module unpack_engine
    import unpack_pkg::*;
#(
    parameter  int MEM_QW = 256,
    localparam int AW     = $clog2(MEM_QW)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        cmd_vn,
    input  logic [1:0]        cmd_vl,
    input  logic              cmd_unsigned,
    input  logic              cmd_rbit,
    input  logic [9:0]        cmd_imm,
    input  logic [7:0]        cmd_num,
    input  logic [7:0]        cyc_cl,
    input  logic [7:0]        cyc_wl,
    input  logic [9:0]        tops,
    input  logic [31:0]       in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [VEC_W-1:0]  wr_data,
    output logic              done
);
    ucmd_t            cmd_q;
    logic             run_q;
    logic             done_q;
    logic             launch;
    logic [LVL_W-1:0] need;
    logic [LVL_W-1:0] level;
    logic [VEC_W-1:0] head;
    logic             have;
    logic             fill;
    logic             last;
    logic             take;

    assign launch = start && !run_q;
    assign need   = vec_bits(cmd_q.vn, cmd_q.vl);
    assign have   = (level >= need);

    assign wr_en    = run_q && (fill || have);
    assign in_ready = run_q && !fill && !have;
    assign take     = in_ready && in_valid;
    assign wr_data  = fill ? '0 : expand_vec(head, cmd_q.vn, cmd_q.vl, cmd_q.uns);
    assign done     = done_q;

    unpack_bitbuf u_bitbuf (
        .clk       (clk),
        .rst       (rst),
        .clear     (launch),
        .push      (take),
        .push_word (in_data),
        .pop       (run_q && !fill && have),
        .pop_bits  (need),
        .head      (head),
        .level     (level)
    );

    unpack_addr_gen #(.AW(AW)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .load (launch),
        .adv  (wr_en),
        .cmd  (cmd_q),
        .addr (wr_addr),
        .fill (fill),
        .last (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= wr_en && last;
            if (launch) begin
                cmd_q <= '{vn: cmd_vn, vl: cmd_vl, uns: cmd_unsigned, rbit: cmd_rbit,
                           imm: cmd_imm, num: cmd_num, cl: cyc_cl, wl: cyc_wl, tops: tops};
                run_q <= 1'b1;
            end else if (wr_en && last) begin
                run_q <= 1'b0;
            end
        end
    end

    // R10: completion only directly after a write
    a_r10_done_after_write: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(wr_en));

    // R10: completion is a single-cycle pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: short vectors carry a zero top lane
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd_q.vl != 2'd3 && cmd_q.vn != 2'd3) |-> (wr_data[127:96] == 32'd0));

    initial a_r8_pow2_mem: assert ((1 << AW) == MEM_QW);

endmodule

// File: tb/unpack_engine_bench.sv
`timescale 1ns/1ps
module unpack_engine_bench;

    localparam int MEM_QW = 256;

    typedef struct packed {
        logic [1:0]  vn;
        logic [1:0]  vl;
        logic        uns;
        logic        r;
        logic [9:0]  imm;
        logic [7:0]  num;
        logic [7:0]  cl;
        logic [7:0]  wl;
        logic [9:0]  tops;
        logic [15:0] seed;
        logic [7:0]  exp_words;
        logic        gappy;
    } tcase_t;

    localparam int NCASE = 11;
    localparam tcase_t CASES [NCASE] = '{
        '{2'd3, 2'd0, 1'b0, 1'b0, 10'd5,    8'd2, 8'd1, 8'd1, 10'd0,    16'd11, 8'd8,  1'b0},
        '{2'd1, 2'd1, 1'b0, 1'b0, 10'd20,   8'd3, 8'd4, 8'd4, 10'd0,    16'd23, 8'd3,  1'b1},
        '{2'd2, 2'd2, 1'b1, 1'b1, 10'd2,    8'd5, 8'd2, 8'd1, 10'h010,  16'd37, 8'd4,  1'b0},
        '{2'd0, 2'd2, 1'b0, 1'b0, 10'd9,    8'd3, 8'd1, 8'd1, 10'd0,    16'd41, 8'd1,  1'b1},
        '{2'd3, 2'd3, 1'b0, 1'b0, 10'h3FF,  8'd3, 8'd1, 8'd1, 10'd0,    16'd53, 8'd2,  1'b0},
        '{2'd3, 2'd0, 1'b1, 1'b0, 10'd40,   8'd7, 8'd1, 8'd3, 10'd0,    16'd61, 8'd12, 1'b1},
        '{2'd1, 2'd0, 1'b1, 1'b1, 10'd8,    8'd5, 8'd3, 8'd2, 10'h3F8,  16'd67, 8'd10, 1'b0},
        '{2'd3, 2'd0, 1'b0, 1'b0, 10'd100,  8'd0, 8'd0, 8'd0, 10'd0,    16'd71, 8'd0,  1'b0},
        '{2'd0, 2'd0, 1'b0, 1'b0, 10'd50,   8'd3, 8'd0, 8'd0, 10'd0,    16'd73, 8'd3,  1'b1},
        '{2'd2, 2'd1, 1'b1, 1'b0, 10'd30,   8'd6, 8'd2, 8'd4, 10'd0,    16'd79, 8'd6,  1'b0},
        '{2'd3, 2'd3, 1'b1, 1'b0, 10'd0,    8'd5, 8'd1, 8'd1, 10'd0,    16'd83, 8'd3,  1'b1}
    };

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [1:0]   cmd_vn, cmd_vl;
    logic         cmd_unsigned, cmd_rbit;
    logic [9:0]   cmd_imm, tops;
    logic [7:0]   cmd_num, cyc_cl, cyc_wl;
    logic [31:0]  in_data;
    logic         in_valid;
    logic         in_ready, wr_en, done;
    logic [7:0]   wr_addr;
    logic [127:0] wr_data;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    logic [7:0]   cap_addr [2];
    logic [127:0] cap_data [2];

    always #10 clk = ~clk;

    unpack_engine #(.MEM_QW(MEM_QW)) u_unpack_engine (
        .clk(clk), .rst(rst), .start(start), .cmd_vn(cmd_vn), .cmd_vl(cmd_vl),
        .cmd_unsigned(cmd_unsigned), .cmd_rbit(cmd_rbit), .cmd_imm(cmd_imm),
        .cmd_num(cmd_num), .cyc_cl(cyc_cl), .cyc_wl(cyc_wl), .tops(tops),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string what);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s", what);
        end
    endtask

    function automatic logic [31:0] gen_word(int seed, int i);
        logic [31:0] s;
        if (seed == 0) return 32'hAAAA5555;
        s = 32'(seed);
        return (s * 32'h9E3779B1) ^ (32'(i + 1) * 32'h85EBCA6B) ^ 32'h5BD1E995;
    endfunction

    function automatic logic [127:0] take_bits(int seed, int p, int n);
        logic [127:0] raw = '0;
        logic [31:0]  w;
        for (int b = 0; b < n; b++) begin
            w = gen_word(seed, (p + b) / 32);
            raw[b] = w[(p + b) % 32];
        end
        return raw;
    endfunction

    function automatic int bits_per(int vn, int vl);
        return (vl == 3) ? 16 : (32 >> vl) * (vn + 1);
    endfunction

    function automatic logic [127:0] model_vec(logic [127:0] raw, int vn, int vl, bit uns);
        logic [127:0] v = '0;
        int w;
        int pos = 0;
        if (vl == 3) begin
            for (int e = 0; e < 4; e++) begin
                w = (e == 3) ? 1 : 5;
                for (int b = 0; b < 32; b++)
                    v[e*32 + b] = (b < w) ? raw[pos + b]
                                 : ((!uns && e < 3) ? raw[pos + w - 1] : 1'b0);
                pos += w;
            end
        end else begin
            w = 32 >> vl;
            for (int e = 0; e <= vn; e++)
                for (int b = 0; b < 32; b++)
                    v[e*32 + b] = (b < w) ? raw[e*w + b] : (uns ? 1'b0 : raw[e*w + w - 1]);
        end
        return v;
    endfunction

    function automatic int model_addr(tcase_t c, int k);
        int wlp = (c.wl == 0) ? 256 : int'(c.wl);
        int idx = int'(c.imm);
        if (c.cl >= c.wl) idx += (k / wlp) * int'(c.cl) + k % wlp;
        else              idx += k;
        if (c.r) idx += int'(c.tops);
        return idx % MEM_QW;
    endfunction

    function automatic bit model_fill(tcase_t c, int k);
        if (c.num == 0 && c.cl == 0 && c.wl == 0) return 1'b1;
        return (c.cl < c.wl) && ((k % int'(c.wl)) >= int'(c.cl));
    endfunction

    task automatic run_case(input int id, input tcase_t c);
        int widx = 0, mk = 0, mp = 0, iter = 0, last_it = -10, nout;
        bit got_done = 0;
        int need = bits_per(int'(c.vn), int'(c.vl));
        logic [127:0] exp_d;
        int exp_a;
        nout = (c.num == 0) ? 256 : int'(c.num);
        @(negedge clk);
        cmd_vn = c.vn; cmd_vl = c.vl; cmd_unsigned = c.uns; cmd_rbit = c.r;
        cmd_imm = c.imm; cmd_num = c.num; cyc_cl = c.cl; cyc_wl = c.wl; tops = c.tops;
        start = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        while (!got_done && iter < 3000) begin
            if (done) begin
                got_done = 1;
                // R10: pulse directly after the last write
                check(iter == last_it + 1, $sformatf("R10 case %0d done at iter %0d expected %0d",
                      id, iter, last_it + 1));
            end
            if (wr_en) begin
                exp_a = model_addr(c, mk);
                if (model_fill(c, mk)) exp_d = '0;
                else begin
                    exp_d = model_vec(take_bits(int'(c.seed), mp, need), int'(c.vn), int'(c.vl), c.uns);
                    mp += need;
                end
                // R5 R6 R7 R8 destination index
                check(int'(wr_addr) == exp_a, $sformatf("R5 R6 R7 R8 case %0d k=%0d addr %h expected %h",
                      id, mk, wr_addr, exp_a[7:0]));
                // R1 R2 R3 R6 vector contents
                check(wr_data == exp_d, $sformatf("R1 R2 R3 R6 case %0d k=%0d data %h expected %h",
                      id, mk, wr_data, exp_d));
                if (mk < 2) begin
                    cap_addr[mk] = wr_addr;
                    cap_data[mk] = wr_data;
                end
                mk++;
                last_it = iter;
            end
            in_data  = gen_word(int'(c.seed), widx);
            in_valid = !(c.gappy && (iter % 3 == 1));
            if (in_valid && in_ready) widx++;
            iter++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(got_done, $sformatf("R10 case %0d done seen %0d expected 1", id, got_done));
        // R9: output count
        check(mk == nout, $sformatf("R9 case %0d writes %0d expected %0d", id, mk, nout));
        // R4: input words consumed
        check(widx == int'(c.exp_words), $sformatf("R4 case %0d words %0d expected %0d",
              id, widx, c.exp_words));
        check(!done && !in_ready && !wr_en, $sformatf("R10 case %0d after done %b%b%b expected 000",
              id, done, in_ready, wr_en));
    endtask

    initial begin
        tcase_t d;
        rst = 1'b1; start = 1'b0; in_valid = 1'b0; in_data = '0;
        cmd_vn = '0; cmd_vl = '0; cmd_unsigned = 1'b0; cmd_rbit = 1'b0;
        cmd_imm = '0; cmd_num = '0; cyc_cl = '0; cyc_wl = '0; tops = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!wr_en && !done && !in_ready, $sformatf("R10 reset %b%b%b expected 000",
              wr_en, done, in_ready));
        rst = 1'b0;
        @(negedge clk);
        check(!wr_en && !done && !in_ready, $sformatf("R10 idle %b%b%b expected 000",
              wr_en, done, in_ready));

        for (int i = 0; i < NCASE; i++) run_case(i, CASES[i]);

        // R2 R8: colour fields from fixed words, start at 0x3FF then wrap
        d = '{2'd3, 2'd3, 1'b0, 1'b0, 10'h3FF, 8'd2, 8'd1, 8'd1, 10'd0, 16'd0, 8'd1, 1'b0};
        run_case(100, d);
        check(cap_addr[0] == 8'hFF, $sformatf("R8 first addr %h expected ff", cap_addr[0]));
        check(cap_addr[1] == 8'h00, $sformatf("R8 second addr %h expected 00", cap_addr[1]));
        check(cap_data[0] == 128'h00000000_FFFFFFF5_0000000A_FFFFFFF5,
              $sformatf("R2 colour 0x5555 %h expected 00000000fffffff50000000afffffff5", cap_data[0]));
        check(cap_data[1] == 128'h00000001_0000000A_FFFFFFF5_0000000A,
              $sformatf("R2 colour 0xaaaa %h expected 000000010000000afffffff50000000a", cap_data[1]));

        // R3: one unsigned byte, upper lanes zero, rest of word discarded
        d = '{2'd0, 2'd2, 1'b1, 1'b0, 10'd7, 8'd1, 8'd1, 8'd1, 10'd0, 16'd0, 8'd1, 1'b0};
        run_case(101, d);
        check(cap_data[0] == 128'h55, $sformatf("R3 single byte %h expected 55", cap_data[0]));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule